// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a clocked host request port to a byte-wide asynchronous static RAM with 8192 locations. The host raises a request with a read/write flag, a 13-bit address and a data byte. While the request is in progress the controller drives the memory's address lines, its two enables of opposite polarity, its output enable and its write strobe. It also drives a tristate data bus, which is split into out, in and drive-enable signals. Every minimum interval in the memory timing (read cycle, write pulse, data setup, chip-select-to-end-of-write, write cycle, recovery after retention) is held by a count of clock cycles. Each count is computed at elaboration time from a clock-period parameter and rounded up.

A separate standby request parks the memory in its low-power retention state, with the active-high enable low. On release, the controller waits one read cycle time before it accepts accesses again. All memory-side signals are registered, so the strobes cannot glitch. The host sees a ready flag, and read data returns with a one-cycle valid pulse.

Top module: `sram_ctrl`

## Requirements
- R1: After reset the memory is deselected with mem_sel_n=1 and mem_sel_hi=1, mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0. host_rvalid is 0, and host_ready is 1 while standby_req is 0.
- R2: An accepted read (host_we=0) holds mem_sel_n=0, mem_oe_n=0 and mem_we_n=1, with the address stable, for RD cycles, where RD = ceil(T_RC_NS/CLK_NS). Between two accesses there is at least one cycle with mem_sel_n=1.
- R3: The byte present on mem_dq_in in the last read cycle appears on host_rdata in the next cycle, together with a host_rvalid pulse exactly one cycle long.
- R4: An accepted write (host_we=1) lasts WR cycles. The first is a setup cycle with mem_we_n=1. Then come WP cycles with mem_we_n=0 and the write byte on mem_dq_out. The remaining cycles have mem_we_n=1. mem_sel_n stays 0 and mem_oe_n stays 1 for the whole write.
- R5: mem_dq_oe is 1 only in cycles where mem_we_n is 0, and is 0 in all other states.
- R6: host_ready is 1 only when the controller is idle and standby_req is 0. A request is taken only in a cycle where host_ready is 1; a request that is held while host_ready is 0 has no effect until host_ready returns.
- R7: While parked, mem_sel_hi=0, mem_sel_n=1, mem_dq_oe=0 and host_ready=0. A standby request raised during an access takes effect only after that access completes.
- R8: When standby_req falls, the controller spends RD cycles recovering (deselected with mem_sel_hi=1, host_ready=0) before it returns to idle. If standby_req rises again during recovery, the controller parks again at once.
- R9: If host_req and standby_req are both 1 in the same idle cycle, the standby wins and the request is dropped: no memory access takes place.
- R10: The derived counts are as follows. WP is the largest of ceil(T_WP_NS/CLK_NS), ceil(T_DS_NS/CLK_NS) and ceil(T_CW_NS/CLK_NS)-1. WR is the larger of ceil(T_WC_NS/CLK_NS) and WP+2. At CLK_NS=20 these give RD=5, WP=3 and WR=5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Access address |
| host_wdata | input | DATA_W | Write byte |
| host_rdata | output | DATA_W | Read byte |
| host_rvalid | output | 1 | One-cycle read-data strobe |
| host_ready | output | 1 | Request can be accepted this cycle |
| standby_req | input | 1 | Park the memory in retention standby |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_sel_n | output | 1 | Active-low memory enable |
| mem_sel_hi | output | 1 | Active-high memory enable (retention control) |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | DATA_W | Data driven to the memory |
| mem_dq_in | input | DATA_W | Data read from the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The standby path and the host access path compete for the same idle cycle. A request and a standby request that arrive together must resolve with the standby first. A standby raised during an access must be deferred until that access ends. The bench provokes both cases: it raises host_req and standby_req in one idle cycle, and it raises standby_req in the cycle after a write is accepted. It also raises standby_req again part way through recovery. Each case is judged cycle by cycle against a queue-based model of the expected pin vectors, and a later read-back confirms that the dropped write never reached the memory.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WRITE = 3'd2,
    ST_PARK  = 3'd3,
    ST_WAKE  = 3'd4
  } ctrl_st_e;

  typedef struct packed {
    logic sel_n;
    logic sel_hi;
    logic oe_n;
    logic we_n;
    logic drive;
  } pin_ctl_t;

  // round a nanosecond minimum up to whole clock cycles, never below one
  function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // write strobe length: pulse width, data setup and select-to-end (the select
  // cycle before the pulse already covers one cycle of the latter)
  function automatic int unsigned write_pulse_cycles(int unsigned period_ns, int unsigned wp_ns,
                                                     int unsigned ds_ns, int unsigned cw_ns);
    return max_u(ns_to_cycles(wp_ns, period_ns),
                 max_u(ns_to_cycles(ds_ns, period_ns), ns_to_cycles(cw_ns, period_ns) - 1));
  endfunction

  // whole write: cycle time, or setup + pulse + one release cycle
  function automatic int unsigned write_total_cycles(int unsigned period_ns, int unsigned wc_ns,
                                                     int unsigned pulse);
    return max_u(ns_to_cycles(wc_ns, period_ns), pulse + 2);
  endfunction

  function automatic pin_ctl_t decode_pins(ctrl_st_e st, int unsigned cnt, int unsigned pulse);
    pin_ctl_t p;
    p = '{sel_n: 1'b1, sel_hi: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
    case (st)
      ST_READ: begin
        p.sel_n = 1'b0;
        p.oe_n  = 1'b0;
      end
      ST_WRITE: begin
        p.sel_n = 1'b0;
        if (cnt >= 1 && cnt <= pulse) begin
          p.we_n  = 1'b0;
          p.drive = 1'b1;
        end
      end
      ST_PARK: p.sel_hi = 1'b0;
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned RD_CYC   = 10,
  parameter int unsigned WR_CYC   = 10,
  parameter int unsigned WAKE_CYC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic             park_req,
  output ctrl_st_e         st_q,
  output ctrl_st_e         st_d,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic             ready,
  output logic             accept,
  output logic             rd_last
);

  logic wr_last;
  logic wake_last;

  assign ready     = (st_q == ST_IDLE) && !park_req;
  assign accept    = ready && req;
  assign rd_last   = (st_q == ST_READ)  && (cnt_q == CNT_W'(RD_CYC - 1));
  assign wr_last   = (st_q == ST_WRITE) && (cnt_q == CNT_W'(WR_CYC - 1));
  assign wake_last = (st_q == ST_WAKE)  && (cnt_q == CNT_W'(WAKE_CYC - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (park_req) begin
          st_d  = ST_PARK;
          cnt_d = '0;
        end else if (req) begin
          st_d  = we ? ST_WRITE : ST_READ;
          cnt_d = '0;
        end
      end
      ST_READ: begin
        if (rd_last) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_WRITE: begin
        if (wr_last) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_PARK: begin
        if (!park_req) begin
          st_d  = ST_WAKE;
          cnt_d = '0;
        end
      end
      ST_WAKE: begin
        if (park_req) begin
          st_d  = ST_PARK;
          cnt_d = '0;
        end else if (wake_last) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  // R8
  wake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PARK && !park_req) |=> (st_q == ST_WAKE && cnt_q == '0));

  // R7
  park_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WRITE && !wr_last) |=> (st_q == ST_WRITE));

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned PULSE_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_st_e          st_d,
  input  logic [CNT_W-1:0]  cnt_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel_hi,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  pin_ctl_t ctl_d;
  pin_ctl_t ctl_q;

  assign ctl_d = decode_pins(st_d, 32'(cnt_d), PULSE_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '{sel_n: 1'b1, sel_hi: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else begin
      ctl_q <= ctl_d;
      if (accept) begin
        mem_addr   <= addr;
        mem_dq_out <= wdata;
      end
    end
  end

  assign mem_sel_n  = ctl_q.sel_n;
  assign mem_sel_hi = ctl_q.sel_hi;
  assign mem_oe_n   = ctl_q.oe_n;
  assign mem_we_n   = ctl_q.we_n;
  assign mem_dq_oe  = ctl_q.drive;

  // R5
  drive_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  // R4
  write_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_sel_n && mem_sel_hi));

  // R7
  parked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sel_hi |-> (mem_sel_n && !mem_dq_oe && mem_we_n));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_last,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_last;
      if (rd_last) rdata <= mem_dq_in;
    end
  end

  // R3
  rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  // R3
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> (rvalid && rdata == $past(mem_dq_in)));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_NS  = 10,
  parameter int unsigned T_RC_NS = 100,
  parameter int unsigned T_WC_NS = 100,
  parameter int unsigned T_WP_NS = 60,
  parameter int unsigned T_CW_NS = 80,
  parameter int unsigned T_DS_NS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              host_ready,
  input  logic              standby_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel_hi,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  // R10
  localparam int unsigned RD_CYC    = ns_to_cycles(T_RC_NS, CLK_NS);
  localparam int unsigned PULSE_CYC = write_pulse_cycles(CLK_NS, T_WP_NS, T_DS_NS, T_CW_NS);
  localparam int unsigned WR_CYC    = write_total_cycles(CLK_NS, T_WC_NS, PULSE_CYC);
  localparam int unsigned WAKE_CYC  = RD_CYC;
  localparam int unsigned MAX_CYC   = max_u(RD_CYC, WR_CYC);
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  ctrl_st_e         st_q;
  ctrl_st_e         st_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             accept;
  logic             rd_last;

  sram_ctrl_fsm #(
    .CNT_W   (CNT_W),
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .WAKE_CYC(WAKE_CYC)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (host_req),
    .we      (host_we),
    .park_req(standby_req),
    .st_q    (st_q),
    .st_d    (st_d),
    .cnt_q   (cnt_q),
    .cnt_d   (cnt_d),
    .ready   (host_ready),
    .accept  (accept),
    .rd_last (rd_last)
  );

  sram_ctrl_pins #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .PULSE_CYC(PULSE_CYC)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_d      (st_d),
    .cnt_d     (cnt_d),
    .accept    (accept),
    .addr      (host_addr),
    .wdata     (host_wdata),
    .mem_addr  (mem_addr),
    .mem_sel_n (mem_sel_n),
    .mem_sel_hi(mem_sel_hi),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe)
  );

  sram_ctrl_rdcap #(
    .DATA_W(DATA_W)
  ) u_rdcap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_last  (rd_last),
    .mem_dq_in(mem_dq_in),
    .rdata    (host_rdata),
    .rvalid   (host_rvalid)
  );

  // R9
  collision_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && host_req && standby_req) |=> (!mem_sel_hi || st_q == ST_PARK));

endmodule

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

  localparam int CLK = 20;
  localparam int RD_E = (100 + CLK - 1) / CLK;
  localparam int WPA  = (60 + CLK - 1) / CLK;
  localparam int WPB  = (40 + CLK - 1) / CLK;
  localparam int WPC  = (80 + CLK - 1) / CLK - 1;
  localparam int WP_E = (WPA > WPB) ? ((WPA > WPC) ? WPA : WPC) : ((WPB > WPC) ? WPB : WPC);
  localparam int WCY  = (100 + CLK - 1) / CLK;
  localparam int WR_E = (WCY > WP_E + 2) ? WCY : WP_E + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0, standby_req = 1'b0;
  logic [12:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic host_rvalid, host_ready;
  logic [12:0] mem_addr;
  logic mem_sel_n, mem_sel_hi, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0] mem_dq_out;
  logic [7:0] mem_dq_in = 8'hEE;

  always #10 clk = ~clk;

  sram_ctrl #(.CLK_NS(CLK)) uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .host_ready(host_ready), .standby_req(standby_req),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel_hi(mem_sel_hi),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural memory on the bench side, and the model's own view of it
  logic [7:0] bmem[int];
  logic [7:0] rmem[int];
  function automatic logic [7:0] pat(int a); return a[7:0] ^ 8'h5A; endfunction
  function automatic logic [7:0] bm_get(int a); return bmem.exists(a) ? bmem[a] : pat(a); endfunction
  function automatic logic [7:0] rm_get(int a); return rmem.exists(a) ? rmem[a] : pat(a); endfunction

  always @(negedge clk) begin
    if (!mem_sel_n && mem_sel_hi && !mem_we_n && mem_dq_oe) bmem[int'(mem_addr)] = mem_dq_out;
    mem_dq_in = (!mem_sel_n && mem_sel_hi && !mem_oe_n && mem_we_n) ? bm_get(int'(mem_addr)) : 8'hEE;
  end

  // reference model: a queue of expected pin vectors, one per cycle
  typedef struct packed {
    logic [2:0] kind;  // 0 idle 1 read 2 write 3 park 4 recover
    logic sel_n, sel_hi, oe_n, we_n, drv, rv;
    logic [12:0] a;
    logic [7:0]  d;
  } vec_t;

  function automatic vec_t mk(logic [2:0] k, logic sn, logic sh, logic oen, logic wen,
                              logic dr, logic rv, logic [12:0] a, logic [7:0] d);
    vec_t v;
    v.kind = k; v.sel_n = sn; v.sel_hi = sh; v.oe_n = oen; v.we_n = wen;
    v.drv = dr; v.rv = rv; v.a = a; v.d = d;
    return v;
  endfunction

  vec_t q[$];
  vec_t cur;
  int mode = 0;  // 0 normal, 1 parked, 2 recovering

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur  = mk(0, 1, 1, 1, 1, 0, 0, 0, 0);
      mode = 0;
    end else if (mode == 2 && standby_req) begin
      q.delete();
      cur  = mk(3, 1, 0, 1, 1, 0, 0, 0, 0);
      mode = 1;
    end else if (q.size() > 0) begin
      cur = q.pop_front();
      if (q.size() == 0 && mode == 2) mode = 0;
    end else if (mode == 1) begin
      if (standby_req) cur = mk(3, 1, 0, 1, 1, 0, 0, 0, 0);
      else begin
        for (int k = 0; k < RD_E; k++) q.push_back(mk(4, 1, 1, 1, 1, 0, 0, 0, 0));
        q.push_back(mk(0, 1, 1, 1, 1, 0, 0, 0, 0));
        cur  = q.pop_front();
        mode = 2;
      end
    end else if (standby_req) begin
      cur  = mk(3, 1, 0, 1, 1, 0, 0, 0, 0);
      mode = 1;
    end else if (host_req) begin
      if (host_we) begin
        for (int k = 0; k < WR_E; k++) begin
          logic p;
          p = (k >= 1) && (k <= WP_E);
          q.push_back(mk(2, 0, 1, 1, !p, p, 0, host_addr, host_wdata));
        end
        q.push_back(mk(0, 1, 1, 1, 1, 0, 0, 0, 0));
        rmem[int'(host_addr)] = host_wdata;
      end else begin
        for (int k = 0; k < RD_E; k++) q.push_back(mk(1, 0, 1, 0, 1, 0, 0, host_addr, 0));
        q.push_back(mk(0, 1, 1, 1, 1, 0, 1, 0, rm_get(int'(host_addr))));
      end
      cur = q.pop_front();
    end else begin
      cur = mk(0, 1, 1, 1, 1, 0, 0, 0, 0);
    end
  end

  function automatic string kind_tag(logic [2:0] k);
    case (k)
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R1";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({kind_tag(cur.kind), " pins"}, {mem_sel_n, mem_sel_hi, mem_oe_n, mem_we_n},
            {cur.sel_n, cur.sel_hi, cur.oe_n, cur.we_n});
      check("R5 drive", mem_dq_oe, cur.drv);
      if (cur.drv) check("R4 wdata", mem_dq_out, cur.d);
      if (!cur.sel_n) check({kind_tag(cur.kind), " addr"}, mem_addr, cur.a);
      check("R6 ready", host_ready, (cur.kind == 0) && !standby_req);
      check("R3 rvalid", host_rvalid, cur.rv);
      if (cur.rv) check("R3 rdata", host_rdata, cur.d);
    end
  end

  task automatic access(bit w, logic [12:0] a, logic [7:0] d);
    @(posedge clk); #1;
    host_req = 1; host_we = w; host_addr = a; host_wdata = d;
    do @(negedge clk); while (!host_ready);
    @(posedge clk); #1;
    host_req = 0;
  endtask

  task automatic rd_get(logic [12:0] a, output logic [7:0] d);
    access(0, a, 0);
    do @(negedge clk); while (!host_rvalid);
    d = host_rdata;
  endtask

  task automatic wait_ready;
    do @(negedge clk); while (!host_ready);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R6 actual=hang expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sel_n", mem_sel_n, 1); check("R1 sel_hi", mem_sel_hi, 1);
    check("R1 oe_we", {mem_oe_n, mem_we_n}, 2'b11); check("R1 drive", mem_dq_oe, 0);
    check("R1 rvalid", host_rvalid, 0); check("R1 ready", host_ready, 1);
    @(posedge clk); #1 rst_n = 1;

    access(1, 13'd0, 8'h00);
    access(1, 13'd8191, 8'hFF);
    access(1, 13'h0A5A, 8'hA5);
    access(1, 13'd5, 8'h3C);
    rd_get(13'd8191, got); check("R3 top address", got, 8'hFF);
    rd_get(13'd0, got);    check("R3 zero address", got, 8'h00);
    rd_get(13'h0A5A, got); check("R3 mid address", got, 8'hA5);
    rd_get(13'd77, got);   check("R3 unwritten", got, pat(77));

    // R6: request held through busy cycles gives back-to-back reads
    @(posedge clk); #1 host_req = 1; host_we = 0; host_addr = 13'd5;
    repeat (14) @(posedge clk);
    #1 host_req = 0;
    wait_ready;

    // R10: strobe length and read length
    access(1, 13'd100, 8'h77);
    n = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (!mem_we_n) n++; end
    check("R10 write pulse", n, WP_E);
    access(0, 13'd100, 0);
    n = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (!mem_sel_n) n++; end
    check("R10 read length", n, RD_E);

    // R9: request and standby in the same idle cycle
    wait_ready;
    @(posedge clk); #1;
    host_req = 1; host_we = 1; host_addr = 13'd200; host_wdata = 8'h11; standby_req = 1;
    @(negedge clk); check("R9 ready", host_ready, 0);
    @(posedge clk); #1 host_req = 0;
    @(negedge clk); check("R9 parked", mem_sel_hi, 0);
    repeat (5) @(posedge clk);
    #1 standby_req = 0;
    n = 0;
    do begin @(negedge clk); if (!host_ready) n++; end while (!host_ready);
    check("R8 recovery", n, RD_E + 1);
    rd_get(13'd200, got); check("R9 dropped write", got, pat(200));

    // R8: re-park during recovery
    @(posedge clk); #1 standby_req = 1;
    repeat (3) @(posedge clk);
    #1 standby_req = 0;
    repeat (2) @(posedge clk);
    #1 standby_req = 1;
    repeat (3) @(posedge clk);
    #1 standby_req = 0;
    wait_ready;

    // R7: standby raised during a write is deferred
    access(1, 13'd300, 8'h42);
    #1 standby_req = 1;
    @(negedge clk); check("R7 write continues", mem_sel_n, 0);
    repeat (10) @(posedge clk);
    #1 standby_req = 0;
    wait_ready;
    rd_get(13'd300, got); check("R7 write kept", got, 8'h42);

    repeat (4) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule